// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block sits beside the main command scheduler of a DDR2 memory controller and keeps the memory refreshed. A free-running interval timer creates one owed refresh each time it expires. A saturating counter tracks the owed refreshes, up to eight postponed at once. While at least one refresh is owed, the block asks the main controller for the command bus. When eight are owed, it raises an urgent request that the controller must honour before issuing any other command.

Once the bus is granted, the block closes every bank with a precharge-all command and waits the row-precharge time. It then issues a refresh and drives only NOP for the full refresh-cycle time. The memory advances its own row counter, so no row address goes out with the refresh. If refreshes are still owed and the grant is still held when that wait ends, another refresh follows at once without a second precharge, because the banks are still closed. A busy flag covers the whole sequence, and the controller releases the grant only after busy falls. All timing values are parameters counted in clock cycles. With the default 250 MHz clock, the 7.8 µs average interval is 1950 cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: The interval timer adds one owed refresh every REFI_CYC clock cycles. After a synchronous reset is released, the owed count first becomes nonzero on exactly the REFI_CYC-th rising edge.
- R2: `bus_req` is high exactly when the owed count is at least one. `bus_req_urgent` is high exactly when it equals MAX_OWED (8). Urgent is never high without `bus_req`.
- R3: The owed count saturates at MAX_OWED, and timer expiries beyond that are lost. Each refresh issued lowers the count by one, so a burst that starts from saturation issues exactly MAX_OWED refreshes and leaves `bus_req` low.
- R4: When `bus_grant` is high while idle with refreshes owed, the next cycle drives precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0 and `dram_a10`=1.
- R5: The first refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, with `dram_a10`=0) is driven exactly PRE_GAP_CYC cycles after the precharge-all. NOP fills the cycles between them.
- R6: After each refresh, only NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) is driven for the next REF_HOLD_CYC-1 cycles.
- R7: At the end of a refresh hold, if refreshes are still owed and `bus_grant` is high, another refresh follows exactly REF_HOLD_CYC cycles after the previous one, with no precharge. Otherwise the sequence ends.
- R8: `ref_busy` is high from the precharge-all cycle through the last NOP of the final refresh hold. It is low in the cycle exactly REF_HOLD_CYC after the last refresh. No command other than NOP is driven while it is low.
- R9: A grant given while no refresh is owed causes no command, and `ref_busy` stays low.
- R10: In the cycle after reset, the outputs are NOP, `ref_busy`=0, `bus_req`=0 and `bus_req_urgent`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | Command bus granted to this block by the main controller |
| bus_req | output | 1 | At least one refresh owed |
| bus_req_urgent | output | 1 | Postponement limit reached; must be granted first |
| ref_busy | output | 1 | Refresh sequence in progress |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_a10 | output | 1 | Address bit 10, high selects all banks on precharge |

## Verification
The hardest state to reach from the ports is a full owed count with further timer expiries on top of it. The saturation and the burst length that follows can only be seen by holding the grant off for many intervals and then counting refreshes. The bench resets before each scenario so that timer expiries fall on known edges. It withholds the grant for ten intervals, checks that the urgent request rises on the eighth expiry, and then grants just after an expiry, so that the whole burst fits before the next one. A second hard case drops the grant in the middle of a two-refresh burst. This shows that the loop decision happens only at the end of the hold, and that one refresh stays owed.

// File: rtl/refsch_pkg.sv
`timescale 1ns/1ps
package refsch_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam dram_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_RP_WAIT,
        SQ_REF,
        SQ_RFC_WAIT
    } seq_state_t;

    function automatic dram_cmd_t cmd_for(seq_state_t s);
        case (s)
            SQ_PRE:  return CMD_PRE;
            SQ_REF:  return CMD_REF;
            default: return CMD_NOP;
        endcase
    endfunction

    function automatic logic a10_for(seq_state_t s);
        return (s == SQ_PRE);
    endfunction

    function automatic logic busy_for(seq_state_t s);
        return (s != SQ_IDLE);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refsch_interval.sv
`timescale 1ns/1ps
module refsch_interval #(
    parameter int REFI_CYC = 1950
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REFI_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/refsch_owed.sv
`timescale 1ns/1ps
module refsch_owed #(
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              dec,
    output logic [OWED_W-1:0] owed,
    output logic              any,
    output logic              full
);
    localparam logic [OWED_W-1:0] CAP = OWED_W'(MAX_OWED);

    logic [OWED_W-1:0] owed_q, owed_d;

    always_comb begin
        owed_d = owed_q;
        case ({inc, dec})
            2'b10:   if (owed_q != CAP)  owed_d = owed_q + 1'b1;
            2'b01:   if (owed_q != '0)   owed_d = owed_q - 1'b1;
            default: owed_d = owed_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) owed_q <= '0;
        else     owed_q <= owed_d;
    end

    assign owed = owed_q;
    assign any  = (owed_q != '0);
    assign full = (owed_q == CAP);
endmodule

// File: rtl/refsch_seq.sv
`timescale 1ns/1ps
module refsch_seq
    import refsch_pkg::*;
#(
    parameter int PRE_GAP_CYC  = 4,
    parameter int REF_HOLD_CYC = 27
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      grant,
    input  logic      pending,
    output logic      ref_fire,
    output logic      busy,
    output dram_cmd_t cmd,
    output logic      a10
);
    localparam int WAIT_MAX = max2(PRE_GAP_CYC, REF_HOLD_CYC);
    localparam int WAIT_W   = (WAIT_MAX > 2) ? $clog2(WAIT_MAX) : 1;
    localparam logic [WAIT_W-1:0] RP_LOAD  = WAIT_W'(PRE_GAP_CYC - 2);
    localparam logic [WAIT_W-1:0] RFC_LOAD = WAIT_W'(REF_HOLD_CYC - 2);

    seq_state_t        st_q, st_d;
    logic [WAIT_W-1:0] wait_q, wait_d;

    always_comb begin
        st_d   = st_q;
        wait_d = wait_q;
        case (st_q)
            SQ_IDLE: begin
                if (grant && pending) st_d = SQ_PRE;
            end
            SQ_PRE: begin
                st_d   = SQ_RP_WAIT;
                wait_d = RP_LOAD;
            end
            SQ_RP_WAIT: begin
                if (wait_q == '0) st_d = SQ_REF;
                else              wait_d = wait_q - 1'b1;
            end
            SQ_REF: begin
                st_d   = SQ_RFC_WAIT;
                wait_d = RFC_LOAD;
            end
            SQ_RFC_WAIT: begin
                if (wait_q == '0) st_d = (grant && pending) ? SQ_REF : SQ_IDLE;
                else              wait_d = wait_q - 1'b1;
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            wait_q <= '0;
        end else begin
            st_q   <= st_d;
            wait_q <= wait_d;
        end
    end

    assign ref_fire = (st_q == SQ_REF);
    assign busy     = busy_for(st_q);
    assign cmd      = cmd_for(st_q);
    assign a10      = a10_for(st_q);
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched
    import refsch_pkg::*;
#(
    parameter int REFI_CYC     = 1950,
    parameter int PRE_GAP_CYC  = 4,
    parameter int REF_HOLD_CYC = 27,
    parameter int MAX_OWED     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_grant,
    output logic bus_req,
    output logic bus_req_urgent,
    output logic ref_busy,
    output logic dram_cs_n,
    output logic dram_ras_n,
    output logic dram_cas_n,
    output logic dram_we_n,
    output logic dram_a10
);
    localparam int OWED_W = $clog2(MAX_OWED + 1);

    logic              tick;
    logic              ref_fire;
    logic              owed_any;
    logic              owed_full;
    logic [OWED_W-1:0] owed_q;
    dram_cmd_t         cmd;

    refsch_interval #(.REFI_CYC(REFI_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    refsch_owed #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_owed (
        .clk  (clk),
        .rst  (rst),
        .inc  (tick),
        .dec  (ref_fire),
        .owed (owed_q),
        .any  (owed_any),
        .full (owed_full)
    );

    refsch_seq #(.PRE_GAP_CYC(PRE_GAP_CYC), .REF_HOLD_CYC(REF_HOLD_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .grant    (bus_grant),
        .pending  (owed_any),
        .ref_fire (ref_fire),
        .busy     (ref_busy),
        .cmd      (cmd),
        .a10      (dram_a10)
    );

    assign bus_req        = owed_any;
    assign bus_req_urgent = owed_full;
    assign dram_cs_n      = cmd.cs_n;
    assign dram_ras_n     = cmd.ras_n;
    assign dram_cas_n     = cmd.cas_n;
    assign dram_we_n      = cmd.we_n;
endmodule

// File: rtl/refsch_chk.sv
`timescale 1ns/1ps
module refsch_chk #(
    parameter int MAX_OWED     = 8,
    parameter int OWED_W       = 4,
    parameter int PRE_GAP_CYC  = 4,
    parameter int REF_HOLD_CYC = 27
) (
    input logic              clk,
    input logic              rst,
    input logic [OWED_W-1:0] owed,
    input logic              req,
    input logic              urgent,
    input logic              busy,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              a10
);
    logic is_nop, is_pre, is_ref;
    assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
    assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
    assign is_ref = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);

    logic [15:0] gap_q;
    logic        last_ref_q;
    logic        rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            gap_q      <= 16'hFFFF;
            last_ref_q <= 1'b0;
        end else if (is_pre || is_ref) begin
            gap_q      <= 16'd1;
            last_ref_q <= is_ref;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        owed <= OWED_W'(MAX_OWED));

    // R2
    urgent_req_chk: assert property (@(posedge clk) disable iff (rst)
        urgent |-> req);

    // R4
    pre_all_banks_chk: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> a10);

    // R5
    rp_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (is_ref && !last_ref_q) |-> (gap_q == 16'(PRE_GAP_CYC)));

    // R6
    rfc_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (last_ref_q && gap_q < 16'(REF_HOLD_CYC)) |-> is_nop);

    // R7
    loop_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (is_ref && last_ref_q) |-> (gap_q == 16'(REF_HOLD_CYC)));

    // R8
    idle_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> is_nop);

    // R10
    always @(posedge clk) begin
        if (rst_d === 1'b1 && rst === 1'b0) begin
            reset_state_chk: assert (is_nop && !busy && !req && !urgent);
        end
    end
endmodule

bind dram_refresh_sched refsch_chk #(
    .MAX_OWED     (MAX_OWED),
    .OWED_W       (OWED_W),
    .PRE_GAP_CYC  (PRE_GAP_CYC),
    .REF_HOLD_CYC (REF_HOLD_CYC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .owed   (owed_q),
    .req    (bus_req),
    .urgent (bus_req_urgent),
    .busy   (ref_busy),
    .cs_n   (dram_cs_n),
    .ras_n  (dram_ras_n),
    .cas_n  (dram_cas_n),
    .we_n   (dram_we_n),
    .a10    (dram_a10)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
    localparam int REFI = 64;
    localparam int TRP  = 3;
    localparam int TRFC = 5;
    localparam int MAXO = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic grant = 1'b0;
    logic req, urg, busy, cs_n, ras_n, cas_n, we_n, a10;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dram_refresh_sched #(
        .REFI_CYC(REFI), .PRE_GAP_CYC(TRP), .REF_HOLD_CYC(TRFC), .MAX_OWED(MAXO)
    ) u0 (
        .clk(clk), .rst(rst), .bus_grant(grant), .bus_req(req), .bus_req_urgent(urg),
        .ref_busy(busy), .dram_cs_n(cs_n), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .dram_we_n(we_n), .dram_a10(a10)
    );

    function automatic logic [3:0] cmd4();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        grant = 1'b0;
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
    endtask

    // Grants the bus and follows one sequence until busy falls.
    task automatic run_burst(input int drop_at, input int exp_refs, input string tag);
        int npre = 0, nref = 0, first_pre = -1, last_ref = -1, fall = -1, c = 0;
        bit bad_nop = 0, bad_gap = 0, bad_a10 = 0, busy_first = 0;
        grant = 1'b1;
        while (fall < 0 && c < 400) begin
            step();
            c++;
            if (c == 1) busy_first = busy;
            if (cmd4() == 4'b0010) begin
                npre++;
                first_pre = c;
                if (a10 !== 1'b1) bad_a10 = 1;
            end else if (cmd4() == 4'b0001) begin
                if (nref == 0) begin
                    if (c - first_pre != TRP) bad_gap = 1;
                end else if (c - last_ref != TRFC) bad_gap = 1;
                if (a10 !== 1'b0) bad_a10 = 1;
                last_ref = c;
                nref++;
            end else if (cmd4() != 4'b0111) begin
                bad_nop = 1;
            end
            if (!busy && c > 1) fall = c;
            if (c == drop_at) grant = 1'b0;
        end
        grant = 1'b0;
        check(busy_first && npre == 1 && first_pre == 1, {"R4 precharge first ", tag}, npre, 1);
        check(!bad_a10, {"R4 a10 level ", tag}, bad_a10, 0);
        check(!bad_gap && first_pre >= 0, {"R5/R7 command spacing ", tag}, bad_gap, 0);
        check(!bad_nop, {"R6 nop only between commands ", tag}, bad_nop, 0);
        check(nref == exp_refs, {"R7 refresh count ", tag}, nref, exp_refs);
        check(fall == last_ref + TRFC, {"R8 busy fall cycle ", tag}, fall, last_ref + TRFC);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(cmd4() == 4'b0111, "R10 reset cmd NOP", cmd4(), 7);
        check(!busy && !req && !urg, "R10 reset flags", {busy, req, urg}, 0);
    endtask

    task automatic t_timer();
        bit early = 0;
        do_reset();
        for (int i = 1; i <= REFI; i++) begin
            step();
            if (i < REFI && req) early = 1;
        end
        check(!early, "R1 req before interval", early, 0);
        check(req && !urg, "R1 req at interval", req, 1);
    endtask

    task automatic t_grant_no_owed();
        bit bad = 0;
        do_reset();
        grant = 1'b1;
        for (int i = 0; i < 30; i++) begin
            step();
            if (busy || cmd4() != 4'b0111) bad = 1;
        end
        grant = 1'b0;
        check(!bad, "R9 grant without owed", bad, 0);
    endtask

    task automatic t_single();
        do_reset();
        repeat (REFI) step();
        run_burst(-1, 1, "single");
        check(!req, "R3 owed cleared single", req, 0);
    endtask

    task automatic t_double();
        do_reset();
        repeat (2 * REFI) step();
        run_burst(-1, 2, "double");
        check(!req, "R3 owed cleared double", req, 0);
    endtask

    task automatic t_saturate();
        bit bad_urg = 0;
        do_reset();
        for (int i = 1; i <= 10 * REFI; i++) begin
            step();
            if (urg != (i >= MAXO * REFI)) bad_urg = 1;
            if (urg && !req) bad_urg = 1;
        end
        check(!bad_urg, "R2 urgent at eighth expiry", bad_urg, 0);
        run_burst(-1, MAXO, "saturated");
        check(!req && !urg, "R3 saturated burst drains", req, 0);
    endtask

    task automatic t_drop();
        bit bad = 0;
        do_reset();
        repeat (2 * REFI) step();
        run_burst(2, 1, "grant dropped");
        check(req && !urg, "R7 one refresh still owed", req, 1);
        for (int i = 0; i < 10; i++) begin
            step();
            if (busy || cmd4() != 4'b0111) bad = 1;
        end
        check(!bad, "R8 idle without grant", bad, 0);
    endtask

    initial begin
        t_reset_state();
        t_timer();
        t_grant_no_owed();
        t_single();
        t_double();
        t_saturate();
        t_drop();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule